// File: doc/BRIEF.md
# Serial Host Register Port

This block is a serial slave through which a host controller reads and writes a single 8-bit control/status register. The host opens a frame by pulling the active-low select low from its idle high level. It then clocks 16 bits in over the serial input, least significant bit first. The first byte is a command; its bit 0 chooses read (1) or write (0). The second byte carries write data, or is a don't-care on a read. All timing follows the serial clock and is unrelated to any line or system timing.

For a read, the register contents come out on the serial output during the data byte. An edge-select input picks the host's sampling edge, and this choice also sets how long the last bit stays on the wire. The output stage is a data bit plus an enable; the pad driver turns these into a three-state pin. A write becomes visible to the core only when a complete 16-bit frame is closed by select rising. On that event the register output takes the new byte and a write-event toggle flips, ready for a synchronizer in the core clock domain.

Top module: `shp_port`

## Requirements
- R1: Raising `cs_n` clears the frame state. Bits on `sdi` are captured on rising `sclk`, least significant bit first: rising edges 1 to 8 carry the command byte and edges 9 to 16 carry the data byte. Command bit 0 = 1 selects read and = 0 selects write.
- R2: A write frame with exactly 16 rising `sclk` edges, closed by `cs_n` rising, loads the data byte into `reg_q` and inverts `wr_tog`.
- R3: A write frame with fewer or more than 16 rising edges leaves `reg_q` and `wr_tog` unchanged.
- R4: Read with `edge_sel`=1: data bit k (k = 0..7) is driven from rising edge 9+k, so it is valid at falling edge 9+k.
- R5: Read with `edge_sel`=0: data bit k is launched at falling edge 8+k, so it is valid at rising edge 9+k.
- R6: With `edge_sel`=1, the enable drops at falling edge 16. With `edge_sel`=0, bit 7 is held through falling edge 16 and the enable drops at rising edge 17.
- R7: `sdo_oe` is low while `cs_n` is high, drops at once when `cs_n` rises mid-read, and stays low throughout write frames and the command byte of read frames.
- R8: While `rst_n` is low, `reg_q` and `wr_tog` are 0 and no frame is in progress.
- R9: A read returns the value stored by the most recent committed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in |
| edge_sel | input | 1 | 1: host samples on falling edges; 0: host samples on rising edges |
| sdo | output | 1 | Serial data out (meaningful while `sdo_oe` is high) |
| sdo_oe | output | 1 | Output enable for the three-state pad |
| reg_q | output | 8 | Register value presented to the core |
| wr_tog | output | 1 | Toggles once per committed write |

## Verification
A table of write/read round trips runs through both edge-select settings. Its data values include all zeros, all ones, alternating patterns and values that differ only in their end bits, so a reversed bit order, a missed bit or an off-by-one launch edge shows up as a wrong byte. Enable and data are checked in both clock phases of every bit, which separates the two tail behaviours: drop at falling edge 16, or hold to rising edge 17. Truncated and overlong write frames, and a read aborted partway, test that only a complete frame commits and that releasing select releases the output.

// File: rtl/shp_pkg.sv
package shp_pkg;

  // Read-window rule: is the output enabled, given the counts of rising (pc)
  // and falling (nc) sclk edges seen since select fell?
  function automatic logic in_window(input logic es, input int pc, input int nc,
                                     input int cw, input int dw);
    if (es) return (pc > cw) && (pc <= cw + dw) && (nc < cw + dw);
    else    return (nc >= cw) && (nc <= cw + dw) && (pc <= cw + dw);
  endfunction

  // Which data bit is on the wire, clamped so the last bit is held.
  function automatic int bit_sel(input logic es, input int pc, input int nc,
                                 input int cw, input int dw);
    int k;
    k = es ? (pc - cw - 1) : (nc - cw);
    if (k > dw - 1) k = dw - 1;
    if (k < 0) k = 0;
    return k;
  endfunction

endpackage

// File: rtl/shp_edge_count.sv
module shp_edge_count #(
  parameter int MAX_CNT = 17,
  parameter int CNT_W   = 5
) (
  input  logic             sclk,
  input  logic             clr,
  output logic [CNT_W-1:0] pcnt,
  output logic [CNT_W-1:0] ncnt
);

  localparam logic [CNT_W-1:0] SAT = CNT_W'(MAX_CNT);

  always_ff @(posedge sclk or posedge clr) begin
    if (clr)             pcnt <= '0;
    else if (pcnt != SAT) pcnt <= pcnt + 1'b1;
  end

  always_ff @(negedge sclk or posedge clr) begin
    if (clr)             ncnt <= '0;
    else if (ncnt != SAT) ncnt <= ncnt + 1'b1;
  end

endmodule

// File: rtl/shp_capture.sv
module shp_capture #(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              sclk,
  input  logic              clr,
  input  logic              sdi,
  input  logic [CNT_W-1:0]  pcnt,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [DATA_W-1:0] data_q
);

  for (genvar g = 0; g < CMD_W; g++) begin : g_cmd
    always_ff @(posedge sclk or posedge clr) begin
      if (clr)                          cmd_q[g] <= 1'b0;
      else if (pcnt == CNT_W'(g))       cmd_q[g] <= sdi;
    end
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_data
    always_ff @(posedge sclk or posedge clr) begin
      if (clr)                            data_q[g] <= 1'b0;
      else if (pcnt == CNT_W'(CMD_W + g)) data_q[g] <= sdi;
    end
  end

endmodule

// File: rtl/shp_commit.sv
module shp_commit #(
  parameter int DATA_W = 8
) (
  input  logic              cs_n,
  input  logic              rst_n,
  input  logic              commit_ok,
  input  logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] reg_q,
  output logic              wr_tog
);

  always_ff @(posedge cs_n or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= '0;
      wr_tog <= 1'b0;
    end else if (commit_ok) begin
      reg_q  <= data_q;
      wr_tog <= ~wr_tog;
    end
  end

endmodule

// File: rtl/shp_port.sv
module shp_port #(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic              edge_sel,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [DATA_W-1:0] reg_q,
  output logic              wr_tog
);

  localparam int FRAME = CMD_W + DATA_W;
  localparam int MAX_CNT = FRAME + 1;
  localparam int CNT_W = $clog2(MAX_CNT + 1);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  // Named internal events
  logic              frame_clr;
  logic [CNT_W-1:0]  pcnt;
  logic [CNT_W-1:0]  ncnt;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] data_q;
  logic              is_read;
  logic              commit_ok;
  logic              in_win;
  logic [IDX_W-1:0]  out_idx;

  assign frame_clr = cs_n | ~rst_n;

  shp_edge_count #(.MAX_CNT(MAX_CNT), .CNT_W(CNT_W)) u_cnt (
    .sclk (sclk),
    .clr  (frame_clr),
    .pcnt (pcnt),
    .ncnt (ncnt)
  );

  shp_capture #(.CMD_W(CMD_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_cap (
    .sclk   (sclk),
    .clr    (frame_clr),
    .sdi    (sdi),
    .pcnt   (pcnt),
    .cmd_q  (cmd_q),
    .data_q (data_q)
  );

  assign is_read   = cmd_q[0];
  assign commit_ok = (pcnt == CNT_W'(FRAME)) && !is_read;

  shp_commit #(.DATA_W(DATA_W)) u_reg (
    .cs_n      (cs_n),
    .rst_n     (rst_n),
    .commit_ok (commit_ok),
    .data_q    (data_q),
    .reg_q     (reg_q),
    .wr_tog    (wr_tog)
  );

  assign in_win  = shp_pkg::in_window(edge_sel, int'(pcnt), int'(ncnt), CMD_W, DATA_W);
  assign out_idx = IDX_W'(shp_pkg::bit_sel(edge_sel, int'(pcnt), int'(ncnt), CMD_W, DATA_W));
  assign sdo_oe  = !cs_n && rst_n && is_read && in_win;
  assign sdo     = sdo_oe ? reg_q[out_idx] : 1'b0;

endmodule

// File: rtl/shp_port_chk.sv
module shp_port_chk #(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input logic             rst_n,
  input logic             sclk,
  input logic             cs_n,
  input logic             edge_sel,
  input logic             sdo_oe,
  input logic             is_read,
  input logic [CNT_W-1:0] pcnt
);

  localparam int FRAME = CMD_W + DATA_W;

  // R7
  cs_idle_tri_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |-> !sdo_oe);

  // R7
  write_quiet_chk: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    (int'(pcnt) >= 1 && !is_read) |-> !sdo_oe);

  // R4
  es1_drive_chk: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
    (is_read && edge_sel && int'(pcnt) > CMD_W && int'(pcnt) <= FRAME) |-> sdo_oe);

  // R5
  es0_drive_chk: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    (is_read && !edge_sel && int'(pcnt) >= CMD_W && int'(pcnt) < FRAME) |-> sdo_oe);

  // R6
  es1_tail_chk: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    (edge_sel && int'(pcnt) == FRAME) |-> !sdo_oe);

  // R6
  past_end_chk: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    (int'(pcnt) == FRAME + 1) |-> !sdo_oe);

endmodule

bind shp_port shp_port_chk #(.CMD_W(CMD_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .rst_n    (rst_n),
  .sclk     (sclk),
  .cs_n     (cs_n),
  .edge_sel (edge_sel),
  .sdo_oe   (sdo_oe),
  .is_read  (is_read),
  .pcnt     (pcnt)
);

// File: tb/shp_port_bench.sv
module shp_port_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       sdi = 1'b0;
  logic       edge_sel = 1'b1;
  logic       sdo;
  logic       sdo_oe;
  logic [7:0] reg_q;
  logic       wr_tog;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model = 8'h00;
  logic       tog_m = 1'b0;

  shp_port u_shp_port (
    .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .edge_sel(edge_sel),
    .sdo(sdo), .sdo_oe(sdo_oe), .reg_q(reg_q), .wr_tog(wr_tog)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic half();
    @(posedge clk);
    #1;
  endtask

  // One frame: nbits rising edges; tail adds the post-frame low phase and rising edge 17.
  task automatic run_frame(input logic rd, input logic es, input logic [7:0] wd,
                           input int nbits, input bit tail,
                           output logic [7:0] got, output logic oe_last);
    logic [15:0] bits;
    logic exp_oe;
    bits = {wd, 7'd0, rd};
    got = 8'h00;
    edge_sel = es;
    cs_n = 1'b0;
    half();
    for (int i = 0; i < nbits; i++) begin
      sdi = bits[i % 16];
      half();
      exp_oe = rd && (es ? (i >= 9 && i <= 15) : (i >= 8 && i <= 16));
      chk(sdo_oe === exp_oe, es ? "R4/R7 oe low phase" : "R5/R7 oe low phase",
          16'(sdo_oe), 16'(exp_oe));
      if (!es && rd && i >= 8 && i <= 15) got[i-8] = sdo;
      sclk = 1'b1;
      half();
      exp_oe = rd && (i >= 8 && i <= 15);
      chk(sdo_oe === exp_oe, es ? "R4/R7 oe high phase" : "R5/R7 oe high phase",
          16'(sdo_oe), 16'(exp_oe));
      if (es && rd && i >= 8 && i <= 15) got[i-8] = sdo;
      sclk = 1'b0;
    end
    if (tail) begin
      half();
      chk(sdo_oe === (rd && !es), "R6 oe after falling edge 16", 16'(sdo_oe), 16'(rd && !es));
      if (rd && !es) chk(sdo === model[7], "R6 bit 7 held", 16'(sdo), 16'(model[7]));
      sclk = 1'b1;
      half();
      chk(sdo_oe === 1'b0, "R6 oe after rising edge 17", 16'(sdo_oe), 16'h0);
      sclk = 1'b0;
    end
    half();
    oe_last = sdo_oe;
    cs_n = 1'b1;
    #1;
    chk(sdo_oe === 1'b0, "R7 oe after select rises", 16'(sdo_oe), 16'h0);
    half();
  endtask

  // {edge_sel, data}
  localparam logic [8:0] VEC [8] = '{
    {1'b1, 8'hA5}, {1'b0, 8'h3C}, {1'b1, 8'h00}, {1'b0, 8'hFF},
    {1'b1, 8'h81}, {1'b0, 8'h5A}, {1'b1, 8'h7E}, {1'b0, 8'h01}
  };

  initial begin
    logic [7:0] got;
    logic oe_l;
    repeat (3) half();
    // R8 reset state
    chk(reg_q === 8'h00, "R8 reg_q in reset", 16'(reg_q), 16'h0);
    chk(wr_tog === 1'b0, "R8 wr_tog in reset", 16'(wr_tog), 16'h0);
    chk(sdo_oe === 1'b0, "R8/R7 oe in reset", 16'(sdo_oe), 16'h0);
    rst_n = 1'b1;
    half();

    // Round trips (R1 R2 R4 R5 R6 R9)
    for (int v = 0; v < 8; v++) begin
      run_frame(1'b0, VEC[v][8], VEC[v][7:0], 16, 1'b0, got, oe_l);
      model = VEC[v][7:0];
      tog_m = ~tog_m;
      chk(reg_q === model, "R2 reg_q after write", 16'(reg_q), 16'(model));
      chk(wr_tog === tog_m, "R2 wr_tog after write", 16'(wr_tog), 16'(tog_m));
      chk(oe_l === 1'b0, "R7 oe during write frame", 16'(oe_l), 16'h0);
      run_frame(1'b1, VEC[v][8], 8'h00, 16, 1'b1, got, oe_l);
      chk(got === model, "R1/R9 read-back byte", 16'(got), 16'(model));
      chk(reg_q === model, "R9 read leaves reg_q", 16'(reg_q), 16'(model));
    end

    // R3 short write
    run_frame(1'b0, 1'b1, 8'h77, 10, 1'b0, got, oe_l);
    chk(reg_q === model, "R3 short frame reg_q", 16'(reg_q), 16'(model));
    chk(wr_tog === tog_m, "R3 short frame wr_tog", 16'(wr_tog), 16'(tog_m));
    // R3 overlong write
    run_frame(1'b0, 1'b0, 8'hC3, 17, 1'b0, got, oe_l);
    chk(reg_q === model, "R3 long frame reg_q", 16'(reg_q), 16'(model));
    chk(wr_tog === tog_m, "R3 long frame wr_tog", 16'(wr_tog), 16'(tog_m));

    // R7 read aborted after 12 rising edges: driving before, released at once after
    run_frame(1'b1, 1'b1, 8'h00, 12, 1'b0, got, oe_l);
    chk(oe_l === 1'b1, "R7 oe driving before abort", 16'(oe_l), 16'h1);
    chk(got[3:0] === model[3:0], "R4 partial read bits", 16'(got[3:0]), 16'(model[3:0]));

    // R8 reset clears committed register
    rst_n = 1'b0;
    half();
    chk(reg_q === 8'h00, "R8 reg_q after reset", 16'(reg_q), 16'h0);
    chk(wr_tog === 1'b0, "R8 wr_tog after reset", 16'(wr_tog), 16'h0);
    rst_n = 1'b1;
    model = 8'h00;
    half();
    run_frame(1'b1, 1'b0, 8'h00, 16, 1'b1, got, oe_l);
    chk(got === 8'h00, "R9 read after reset", 16'(got), 16'h0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule